// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Access Controller

This block sits between a synchronous host and an asynchronous pseudo-SRAM of one million 16-bit words. The host offers one request at a time over a valid/ready handshake: a 20-bit word address, a read/write flag, 16 bits of write data and a two-bit byte-lane enable. The controller turns each request into a single memory bus cycle. It drives the active-low chip-enable, output-enable, write-enable and the two byte-lane strobes from registers. It keeps the sleep pin high, which keeps the device out of its low-power state. It also provides the data-bus output value and its output-enable, so that a tristate buffer at the chip edge can be built from them.

Every timing interval is a whole number of system clocks. Each count is the ceiling of a nanosecond limit divided by the clock period `CLK_NS`. The limits are: the access and cycle time, the byte-strobe pulse, the chip-enable high gap between accesses, and the bus-release time after a read. All control strobes of an access fall on the same clock edge and rise on the same later edge. On a write, the data bus is driven for one more cycle after the strobes rise. On a read, the bus is sampled on the edge where the strobes rise, and the result is returned with a one-cycle valid strobe. Byte lanes that were not enabled read back as zero.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, chip-enable, output-enable, write-enable and both byte strobes are high, the data-bus output-enable is low, `req_ready` is high and `rd_valid` is low.
- R2: A write with a non-zero byte enable holds chip-enable, write-enable and the selected strobes low for ACC_CYC = max(ceil(T_ACC_NS/CLK_NS), ceil(T_STROBE_NS/CLK_NS)) cycles (4 at the defaults), while output-enable stays high. Lower strobe low means `req_be[0]` (bits 7:0). Upper strobe low means `req_be[1]` (bits 15:8). Only the enabled bytes change in memory.
- R3: A read with a non-zero byte enable holds chip-enable, output-enable and the selected strobes low for ACC_CYC cycles, while write-enable stays high. `rd_valid` pulses for exactly one cycle, carrying the bus value on the enabled lanes and zero on the lanes that were not enabled.
- R4: The data bus is driven from the edge where write-enable falls until one cycle after it rises, which is ACC_CYC+1 cycles in total. It is never driven while output-enable is low.
- R5: Between two accesses, chip-enable stays high for at least GAP_CYC = ceil(T_GAP_NS/CLK_NS) cycles. After a read it also stays high for at least ceil(T_REL_NS/CLK_NS) cycles before the bus is driven. At the defaults, back-to-back accesses are 7 cycles apart, with chip-enable high for 3 of them.
- R6: `req_ready` is low from the accepting edge until recovery ends, which is 6 cycles at the defaults. It is never high while chip-enable is low.
- R7: While chip-enable is low, the memory address equals the accepted request address and does not change.
- R8: Chip-enable never stays low for more than ACC_CYC consecutive cycles. This keeps every access far below the 32 µs maximum cycle length.
- R9: A request with byte enable 00 starts no bus cycle, and chip-enable stays high. A write leaves memory unchanged. A read returns `rd_valid` one cycle after acceptance with data zero. `req_ready` stays high.
- R10: The sleep output is held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enable, bit 0 = bits 7:0 |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 20 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_sleep_n | output | 1 | Low-power control, held high |
| dq_out | output | 16 | Value to drive on the data bus |
| dq_oe | output | 1 | Data-bus drive enable |
| dq_in | input | 16 | Value seen on the data bus |

## Verification
The bench runs against a small byte-lane-aware memory model. The model returns fixed filler patterns on deselected lanes, so any missing lane mask shows up in the read data. Full-word, lower-only and upper-only writes are each followed by reads with different enables. These tell apart correct strobe-to-lane mapping, correct read masking and stray writes to the wrong lane. Requests with both enables clear show whether an empty request is truly skipped. A held-valid back-to-back pair measures the chip-enable high gap and the access period, which separates a correct recovery from one cut short.

// File: rtl/psram_pkg.sv
// Shared types and helpers for the pseudo-SRAM controller.
// Assumes: all timing values are positive integers in nanoseconds.
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_WHOLD = 3'd3,
        ST_RECOV = 3'd4
    } psr_state_t;

    // Number of whole clocks covering a nanosecond interval.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_timer.sv
// Down-counter that measures the length of each controller phase.
// Assumes: load takes priority; done is high when the count is zero.
module psram_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/psram_fsm.sv
// Access sequencer: accepts requests, steps through the access, write-hold
// and recovery phases, and drives registered control strobes.
// Assumes: phase counts are at least 1; the timer reports done when a
// loaded phase has elapsed.
module psram_fsm
    import psram_pkg::*;
#(
    parameter int ACC_CYC = 4,
    parameter int RD_REC  = 2,
    parameter int WR_REC  = 1,
    parameter int GAP_CYC = 2,
    parameter int REL_CYC = 1,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_be,
    output logic             req_ready,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    input  logic             tmr_done,
    output logic             capture,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             ub_n,
    output logic             lb_n,
    output logic             dq_oe
);
    localparam int MON_W = CNT_W + 2;

    psr_state_t state, state_nx;
    logic       empty;
    logic       start;
    logic       ending;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign empty     = (req_be == 2'b00);
    assign start     = accept && !empty;
    assign ending    = ((state == ST_READ) || (state == ST_WRITE)) && tmr_done;
    assign capture   = ((state == ST_READ) && tmr_done) || (accept && empty && !req_write);

    // Choose the next phase and the length to load for it.
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: if (start) begin
                state_nx = req_write ? ST_WRITE : ST_READ;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(ACC_CYC - 1);
            end
            ST_READ: if (tmr_done) begin
                state_nx = ST_RECOV;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RD_REC - 1);
            end
            ST_WRITE: if (tmr_done) state_nx = ST_WHOLD;
            ST_WHOLD: begin
                state_nx = ST_RECOV;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WR_REC - 1);
            end
            ST_RECOV: if (tmr_done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Registered strobes: all fall at the start edge, all rise at the end edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            ub_n  <= 1'b1;
            lb_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else if (start) begin
            ce_n  <= 1'b0;
            lb_n  <= !req_be[0];
            ub_n  <= !req_be[1];
            we_n  <= !req_write;
            oe_n  <= req_write;
            dq_oe <= req_write;
        end else if (ending) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            ub_n  <= 1'b1;
            lb_n  <= 1'b1;
        end else if (state == ST_WHOLD) begin
            dq_oe <= 1'b0;
        end
    end

    // Checking monitors: run lengths of chip-enable low and high.
    logic [MON_W-1:0] lo_cnt;
    logic [MON_W-1:0] hi_cnt;

    // Count consecutive cycles with chip-enable low and high (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= MON_W'(imax(GAP_CYC, REL_CYC));
        end else if (ce_n) begin
            lo_cnt <= '0;
            if (hi_cnt < MON_W'(imax(GAP_CYC, REL_CYC))) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
            if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // R2
    we_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && oe_n && !(ub_n && lb_n)));
    // R3
    oe_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!ce_n && we_n && !(ub_n && lb_n)));
    // R4
    bus_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !dq_oe);
    // R4
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe);
    // R5
    ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> (hi_cnt >= MON_W'(GAP_CYC)));
    // R5
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (hi_cnt >= MON_W'(REL_CYC)));
    // R6
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> !req_ready);
    // R8
    cycle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt <= MON_W'(ACC_CYC));
endmodule

// File: rtl/psram_datapath.sv
// Address, write-data and read-data registers of the controller.
// Assumes: load marks request acceptance; capture marks the edge on which
// the bus value (or zero, for an empty read) is taken.
module psram_datapath #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    logic [1:0]        lane_en;
    logic [1:0]        mask_sel;
    logic [DATA_W-1:0] masked;

    // Hold the request fields for the whole bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
            lane_en  <= '0;
        end else if (load) begin
            mem_addr <= req_addr;
            dq_out   <= req_wdata;
            lane_en  <= req_be;
        end
    end

    assign mask_sel = load ? req_be : lane_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] = mask_sel[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end

    // Capture masked read data and raise the one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= masked;
        end
    end
endmodule

// File: rtl/psram_ctrl.sv
// Top of the pseudo-SRAM controller: derives clock counts from the
// nanosecond limits and joins timer, sequencer and datapath.
// Assumes: one request in flight; the memory samples the bus asynchronously.
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int CLK_NS      = 20,
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int T_ACC_NS    = 70,
    parameter int T_STROBE_NS = 60,
    parameter int T_GAP_NS    = 30,
    parameter int T_REL_NS    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic              mem_sleep_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);
    localparam int ACC_CYC = imax(imax(ns_to_cyc(T_ACC_NS, CLK_NS),
                                       ns_to_cyc(T_STROBE_NS, CLK_NS)), 1);
    localparam int GAP_CYC = imax(ns_to_cyc(T_GAP_NS, CLK_NS), 1);
    localparam int REL_CYC = ns_to_cyc(T_REL_NS, CLK_NS);
    localparam int RD_REC  = imax(imax(GAP_CYC, REL_CYC), 1);
    localparam int WR_REC  = imax(GAP_CYC - 1, 1);
    localparam int MAXC    = imax(ACC_CYC, RD_REC);
    localparam int CNT_W   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             capture;

    assign mem_sleep_n = 1'b1;

    psram_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psram_fsm #(
        .ACC_CYC (ACC_CYC),
        .RD_REC  (RD_REC),
        .WR_REC  (WR_REC),
        .GAP_CYC (GAP_CYC),
        .REL_CYC (REL_CYC),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_be    (req_be),
        .req_ready (req_ready),
        .accept    (accept),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_done  (tmr_done),
        .capture   (capture),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .ub_n      (mem_ub_n),
        .lb_n      (mem_lb_n),
        .dq_oe     (dq_oe)
    );

    psram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .capture   (capture),
        .dq_in     (dq_in),
        .mem_addr  (mem_addr),
        .dq_out    (dq_out),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

// File: tb/psram_ctrl_bench.sv
`timescale 1ns/1ps
module psram_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_sleep_n;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic [15:0] dq_in;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem [0:255];

    always #10 clk = ~clk;

    psram_ctrl u_psram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_sleep_n(mem_sleep_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // Memory model: byte-lane writes during write overlap, filler on idle lanes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
        end else if (!mem_ce_n && !mem_we_n) begin
            if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  <= dq_out[7:0];
            if (!mem_ub_n) mem[mem_addr[7:0]][15:8] <= dq_out[15:8];
        end
    end
    assign dq_in[15:8] = (!mem_ce_n && !mem_oe_n && !mem_ub_n) ? mem[mem_addr[7:0]][15:8] : 8'hA5;
    assign dq_in[7:0]  = (!mem_ce_n && !mem_oe_n && !mem_lb_n) ? mem[mem_addr[7:0]][7:0]  : 8'h5A;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-request observations.
    int n_ce, n_we, n_oe, n_dq, n_busy, n_ub, n_lb, n_rdv, n_bad_addr, n_clash, n_sleep;
    logic [15:0] got;

    task automatic run_req(input bit wr, input logic [19:0] a, input logic [15:0] d,
                           input logic [1:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        n_ce = 0; n_we = 0; n_oe = 0; n_dq = 0; n_busy = 0; n_ub = 0; n_lb = 0;
        n_rdv = 0; n_bad_addr = 0; n_clash = 0; n_sleep = 0; got = 16'hxxxx;
        for (int i = 1; i <= 20; i++) begin
            if (i > 1) @(negedge clk);
            if (!mem_ce_n) begin n_ce++; if (mem_addr != a) n_bad_addr++; end
            if (!mem_we_n) n_we++;
            if (!mem_oe_n) n_oe++;
            if (!mem_ub_n) n_ub++;
            if (!mem_lb_n) n_lb++;
            if (dq_oe) n_dq++;
            if (dq_oe && !mem_oe_n) n_clash++;
            if (!mem_sleep_n) n_sleep++;
            if (rd_valid) begin n_rdv++; got = rd_data; end
            if (!req_ready) n_busy++;
            else break;
        end
    endtask

    task automatic t_reset;
        check(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n, "R1 strobes",
              {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'h1f);
        check(!dq_oe && req_ready && !rd_valid, "R1 ready/bus",
              {dq_oe, req_ready, rd_valid}, 3'b010);
        check(mem_sleep_n, "R10 sleep", mem_sleep_n, 1);
    endtask

    task automatic t_write_word;
        run_req(1'b1, 20'd10, 16'h1234, 2'b11);
        check(n_ce == 4, "R2 ce low cycles", n_ce, 4);
        check(n_we == 4 && n_oe == 0, "R2 we low, oe high", n_we * 16 + n_oe, 64);
        check(n_ub == 4 && n_lb == 4, "R2 both strobes", n_ub * 16 + n_lb, 68);
        check(n_dq == 5 && n_clash == 0, "R4 drive window", n_dq, 5);
        check(n_busy == 6, "R6 ready low cycles", n_busy, 6);
        check(n_bad_addr == 0, "R7 address held", n_bad_addr, 0);
        check(n_sleep == 0, "R10 sleep during write", n_sleep, 0);
    endtask

    task automatic t_read_word(input logic [19:0] a, input logic [15:0] exp);
        run_req(1'b0, a, 16'h0, 2'b11);
        check(n_ce == 4 && n_oe == 4 && n_we == 0, "R3 read strobes", n_ce * 16 + n_oe, 68);
        check(n_rdv == 1 && got == exp, "R3 read data", got, exp);
        check(n_dq == 0 && n_clash == 0, "R4 no drive on read", n_dq, 0);
        check(n_ce <= 4, "R8 ce low bound", n_ce, 4);
    endtask

    task automatic t_lanes;
        run_req(1'b1, 20'd10, 16'hFF77, 2'b01);
        check(n_lb == 4 && n_ub == 0, "R2 lower-only strobes", n_lb * 16 + n_ub, 64);
        run_req(1'b0, 20'd10, 16'h0, 2'b10);
        check(n_ub == 4 && n_lb == 0 && got == 16'h1200, "R3 upper-only read", got, 16'h1200);
        run_req(1'b0, 20'd10, 16'h0, 2'b01);
        check(got == 16'h0077, "R3 lower-only read", got, 16'h0077);
        run_req(1'b1, 20'd10, 16'hAB00, 2'b10);
        check(n_ub == 4 && n_lb == 0, "R2 upper-only strobes", n_ub * 16 + n_lb, 64);
        t_read_word(20'd10, 16'hAB77);
    endtask

    task automatic t_empty;
        run_req(1'b1, 20'd10, 16'hDEAD, 2'b00);
        check(n_ce == 0 && n_we == 0 && n_busy == 0, "R9 empty write no cycle", n_ce, 0);
        t_read_word(20'd10, 16'hAB77);
        run_req(1'b0, 20'd10, 16'h0, 2'b00);
        check(n_ce == 0 && n_busy == 0, "R9 empty read no cycle", n_ce + n_busy, 0);
        check(n_rdv == 1 && got == 16'h0000, "R9 empty read data", got, 0);
    endtask

    task automatic t_back_to_back;
        int first_lo, second_lo, hi_run, idx;
        logic seen_rdy, dropped;
        first_lo = -1; second_lo = -1; hi_run = 0; seen_rdy = 1'b0; dropped = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'd200; req_be = 2'b11;
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            idx = i;
            if (!mem_ce_n) begin
                if (first_lo < 0) first_lo = idx;
                else if (second_lo < 0 && hi_run > 0) second_lo = idx;
            end else if (first_lo >= 0 && second_lo < 0) begin
                hi_run++;
            end
            if (!dropped) begin
                if (req_ready) seen_rdy = 1'b1;
                else if (seen_rdy) begin req_valid = 1'b0; dropped = 1'b1; end
            end
        end
        req_valid = 1'b0;
        check(hi_run == 3, "R5 ce high gap", hi_run, 3);
        check(second_lo - first_lo == 7, "R5 access period", second_lo - first_lo, 7);
    endtask

    initial begin : watchdog
        #4000000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_word();
        t_read_word(20'd10, 16'h1234);
        t_lanes();
        t_empty();
        run_req(1'b1, 20'd200, 16'h5A5A, 2'b11);
        t_read_word(20'd200, 16'h5A5A);
        t_back_to_back();
        repeat (10) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule